// File: doc/BRIEF.md
# DMA-Fed Serial Write Channel Sequencer

This block is the control engine of one initiator channel on an interprocessor serial link. It writes a burst of registers on the far side of the link. Software arms the channel with an enable bit and a DMA-assist bit. The sequencer then asks a DMA engine for the write payload and collects the delivered 32-bit words into a small bank of data slots. It runs a CRC-8 over the whole frame one byte per clock. Only after that does it stream the frame byte by byte to the link transmitter and wait for the target to acknowledge.

An acknowledge sets a sticky status bit, and an interrupt follows when its enable is set. A repeat bit then chooses between two endings. With repeat set, the channel goes straight back to requesting the DMA. With repeat clear, it settles in idle until software arms it again. If no acknowledge arrives in time, an error bit is set and the channel stops. Dropping the enable bit stops any transfer at once.

The states are S_IDLE, S_LOAD, S_CRC, S_SEND and S_WAIT. The transitions are:
- S_IDLE to S_LOAD when the channel is armed.
- S_LOAD to S_CRC when the last word is accepted.
- S_CRC to S_SEND once the CRC has covered every byte.
- S_SEND to S_WAIT when the CRC byte is accepted.
- S_WAIT to S_LOAD on an acknowledge with repeat set.
- S_WAIT to S_IDLE on an acknowledge with repeat clear, or on a timeout.
- Any active state to S_IDLE when the enable bit is low.

Top module: `sdw_chan_seq`

## Requirements
- R1: A transfer starts only on the rising of (cfg_en AND cfg_dma_assist) while idle. dma_req is high at the clock after that edge. With cfg_dma_assist low, dma_req stays low.
- R2: While dma_req is high, the block takes one word in each cycle that dma_valid is high. dma_req drops at the clock after the word that completes the programmed count is taken, so no further word is consumed. A count of 0 acts as 1, and a count above WORDS acts as WORDS.
- R3: The frame is sent in this order: the header byte, then the four address bytes, then the data words, then the CRC byte. Address and data are sent most significant byte first. The first word delivered by the DMA is the most significant word and occupies the highest used slot, so the words are sent in DMA arrival order. tx_last is high only on the CRC byte.
- R4: The CRC byte is CRC-8 with polynomial 0x07, initial value 0x00, no reflection and no final XOR. It covers the header, address and data bytes in send order. It is computed one byte per clock before the first byte is offered.
- R5: A byte offered with tx_valid is held unchanged until tx_ready accepts it.
- R6: An rx_ack in S_WAIT sets sts_ack. sts_ack_clr clears it, and a set in the same cycle wins. irq equals sts_ack AND cfg_ack_ie.
- R7: After an acknowledge with cfg_dma_repeat set, dma_req rises again at the next clock. With cfg_dma_repeat clear, the block returns to idle and raises no request until it is armed again.
- R8: If no acknowledge arrives within cfg_timeout cycles in S_WAIT, err_tmo is set and the block goes idle with no request. err_clr clears err_tmo. An rx_ack outside S_WAIT has no effect on sts_ack.
- R9: If cfg_en is low in any active state, the block is idle at the next clock, with dma_req and tx_valid low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_en | input | 1 | Channel enable; low aborts |
| cfg_dma_assist | input | 1 | DMA assist enable; needed to arm |
| cfg_dma_repeat | input | 1 | Re-request the DMA after each acknowledge |
| cfg_ack_ie | input | 1 | Acknowledge interrupt enable |
| cfg_word_cnt | input | CNT_W | Data words per frame (clamped to 1..WORDS) |
| cfg_hdr | input | 8 | Frame header byte |
| cfg_addr | input | 32 | Target write address |
| cfg_timeout | input | TMO_W | Acknowledge timeout in cycles |
| sts_ack_clr | input | 1 | Write-1-to-clear pulse for sts_ack |
| err_clr | input | 1 | Write-1-to-clear pulse for err_tmo |
| dma_req | output | 1 | Request to the DMA engine |
| dma_valid | input | 1 | DMA word valid |
| dma_data | input | 32 | DMA word |
| tx_valid | output | 1 | Frame byte offered to transmitter |
| tx_ready | input | 1 | Transmitter takes the byte |
| tx_data | output | 8 | Frame byte |
| tx_last | output | 1 | Marks the CRC byte |
| rx_ack | input | 1 | Acknowledge frame received |
| sts_ack | output | 1 | Acknowledge-received status |
| err_tmo | output | 1 | Acknowledge timeout error |
| irq | output | 1 | Acknowledge interrupt |

## Verification
The bench sends frames of one, two and four words, with gaps in DMA delivery and backpressure from the transmitter. A design that put the words in the wrong slots or computed the CRC wrongly would produce scoreboard mismatches. A request that fails to drop after the count is reached would show up as a word left in the DMA queue being consumed. In repeat mode the bench expects a second request right after the acknowledge. In one-shot mode a lingering request would be caught. The bench also withholds the acknowledge to force a timeout, sends an acknowledge while idle to confirm it is ignored, and removes the enable bit mid-send to confirm the abort.

// File: rtl/sdw_pkg.sv
package sdw_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_LOAD,
        S_CRC,
        S_SEND,
        S_WAIT
    } seq_state_t;

    // one byte through CRC-8, polynomial x^8+x^2+x+1, MSB first
    function automatic logic [7:0] crc8_step(input logic [7:0] c, input logic [7:0] d);
        logic [7:0] x;
        x = c ^ d;
        for (int b = 0; b < 8; b++) begin
            x = x[7] ? ((x << 1) ^ 8'h07) : (x << 1);
        end
        return x;
    endfunction

endpackage

// File: rtl/sdw_crc8.sv
module sdw_crc8 (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr,
    input  logic       en,
    input  logic [7:0] din,
    output logic [7:0] crc
);
    import sdw_pkg::*;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            crc <= 8'h00;
        end else if (clr) begin
            crc <= 8'h00;
        end else if (en) begin
            crc <= crc8_step(crc, din);
        end
    end
endmodule

// File: rtl/sdw_payload.sv
module sdw_payload #(
    parameter int WORDS  = 4,
    parameter int SLOT_W = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic [SLOT_W-1:0]       wr_slot,
    input  logic [31:0]             wr_data,
    output logic [WORDS-1:0][31:0]  slots
);
    for (genvar g = 0; g < WORDS; g++) begin : g_slot
        logic [31:0] word_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                word_q <= '0;
            end else if (wr_en && (wr_slot == SLOT_W'(g))) begin
                word_q <= wr_data;
            end
        end
        assign slots[g] = word_q;
    end
endmodule

// File: rtl/sdw_ack_timer.sv
module sdw_ack_timer #(
    parameter int TMO_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [TMO_W-1:0] limit,
    output logic             expired
);
    logic [TMO_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run) begin
            cnt_q <= '0;
        end else if (cnt_q != limit) begin
            cnt_q <= cnt_q + TMO_W'(1);
        end
    end

    assign expired = run && (cnt_q == limit);

    // R8: the timer never fires before it has been running
    p_tmo_needs_run_r8: assert property (@(posedge clk) disable iff (!rst_n)
        expired && (limit != '0) |-> $past(run));
endmodule

// File: rtl/sdw_chan_seq.sv
module sdw_chan_seq #(
    parameter int WORDS = 4,
    parameter int TMO_W = 16,
    parameter int CNT_W = $clog2(WORDS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_en,
    input  logic             cfg_dma_assist,
    input  logic             cfg_dma_repeat,
    input  logic             cfg_ack_ie,
    input  logic [CNT_W-1:0] cfg_word_cnt,
    input  logic [7:0]       cfg_hdr,
    input  logic [31:0]      cfg_addr,
    input  logic [TMO_W-1:0] cfg_timeout,
    input  logic             sts_ack_clr,
    input  logic             err_clr,
    output logic             dma_req,
    input  logic             dma_valid,
    input  logic [31:0]      dma_data,
    output logic             tx_valid,
    input  logic             tx_ready,
    output logic [7:0]       tx_data,
    output logic             tx_last,
    input  logic             rx_ack,
    output logic             sts_ack,
    output logic             err_tmo,
    output logic             irq
);
    import sdw_pkg::*;

    localparam int SLOT_W    = (WORDS > 1) ? $clog2(WORDS) : 1;
    localparam int FRAME_LEN = 5 + 4 * WORDS;
    localparam int IDX_W     = $clog2(FRAME_LEN + 1);

    seq_state_t              state_q, state_d;
    logic                    arm_q;
    logic [CNT_W-1:0]        cnt_q, wcnt_q, eff_cnt;
    logic [IDX_W-1:0]        idx_q, body_len;
    logic                    sts_ack_q, err_tmo_q;
    logic                    start, load_last, dma_take, tmo_hit;
    logic [SLOT_W-1:0]       wr_slot, rd_slot;
    logic [IDX_W-1:0]        data_ofs;
    logic [WORDS-1:0][31:0]  slots;
    logic [31:0]             rd_word;
    logic [7:0]              cur_byte, crc_val;

    // ---------------- control decode ----------------
    always_comb begin
        if (cfg_word_cnt == '0) begin
            eff_cnt = CNT_W'(1);
        end else if (cfg_word_cnt > CNT_W'(WORDS)) begin
            eff_cnt = CNT_W'(WORDS);
        end else begin
            eff_cnt = cfg_word_cnt;
        end
    end

    assign start     = (state_q == S_IDLE) && cfg_en && cfg_dma_assist && !arm_q;
    assign dma_take  = (state_q == S_LOAD) && dma_valid;
    assign load_last = dma_take && (wcnt_q == cnt_q - CNT_W'(1));
    assign body_len  = IDX_W'(5) + (IDX_W'(cnt_q) << 2);
    assign wr_slot   = SLOT_W'(cnt_q - CNT_W'(1) - wcnt_q);

    // ---------------- next state ----------------
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: if (start) state_d = S_LOAD;
            S_LOAD: if (load_last) state_d = S_CRC;
            S_CRC:  if (idx_q == body_len - IDX_W'(1)) state_d = S_SEND;
            S_SEND: if (tx_ready && (idx_q == body_len)) state_d = S_WAIT;
            S_WAIT: begin
                if (rx_ack) begin
                    state_d = cfg_dma_repeat ? S_LOAD : S_IDLE;
                end else if (tmo_hit) begin
                    state_d = S_IDLE;
                end
            end
            default: state_d = S_IDLE;
        endcase
        if ((state_q != S_IDLE) && !cfg_en) begin
            state_d = S_IDLE;
        end
    end

    // ---------------- state register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // ---------------- counters and status ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            arm_q     <= 1'b0;
            cnt_q     <= CNT_W'(1);
            wcnt_q    <= '0;
            idx_q     <= '0;
            sts_ack_q <= 1'b0;
            err_tmo_q <= 1'b0;
        end else begin
            arm_q <= cfg_en && cfg_dma_assist;

            if ((state_d == S_LOAD) && (state_q != S_LOAD)) begin
                cnt_q  <= eff_cnt;
                wcnt_q <= '0;
            end else if (dma_take) begin
                wcnt_q <= wcnt_q + CNT_W'(1);
            end

            if (state_d != state_q) begin
                idx_q <= '0;
            end else if ((state_q == S_CRC) || ((state_q == S_SEND) && tx_ready)) begin
                idx_q <= idx_q + IDX_W'(1);
            end

            if ((state_q == S_WAIT) && rx_ack) begin
                sts_ack_q <= 1'b1;
            end else if (sts_ack_clr) begin
                sts_ack_q <= 1'b0;
            end

            if ((state_q == S_WAIT) && !rx_ack && tmo_hit) begin
                err_tmo_q <= 1'b1;
            end else if (err_clr) begin
                err_tmo_q <= 1'b0;
            end
        end
    end

    // ---------------- frame byte selection ----------------
    always_comb begin
        data_ofs = idx_q - IDX_W'(5);
        rd_slot  = SLOT_W'(IDX_W'(cnt_q) - IDX_W'(1) - (data_ofs >> 2));
        rd_word  = slots[rd_slot];
        if (idx_q == '0) begin
            cur_byte = cfg_hdr;
        end else if (idx_q < IDX_W'(5)) begin
            unique case (idx_q[2:0])
                3'd1:    cur_byte = cfg_addr[31:24];
                3'd2:    cur_byte = cfg_addr[23:16];
                3'd3:    cur_byte = cfg_addr[15:8];
                default: cur_byte = cfg_addr[7:0];
            endcase
        end else begin
            unique case (data_ofs[1:0])
                2'd0:    cur_byte = rd_word[31:24];
                2'd1:    cur_byte = rd_word[23:16];
                2'd2:    cur_byte = rd_word[15:8];
                default: cur_byte = rd_word[7:0];
            endcase
        end
    end

    // ---------------- outputs ----------------
    always_comb begin
        dma_req  = (state_q == S_LOAD);
        tx_valid = (state_q == S_SEND);
        tx_last  = (state_q == S_SEND) && (idx_q == body_len);
        tx_data  = (idx_q == body_len) ? crc_val : cur_byte;
        sts_ack  = sts_ack_q;
        err_tmo  = err_tmo_q;
        irq      = sts_ack_q && cfg_ack_ie;
    end

    // ---------------- sub-blocks ----------------
    sdw_payload #(.WORDS(WORDS), .SLOT_W(SLOT_W)) u_payload (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (dma_take),
        .wr_slot (wr_slot),
        .wr_data (dma_data),
        .slots   (slots)
    );

    sdw_crc8 u_crc (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (state_q == S_LOAD),
        .en    (state_q == S_CRC),
        .din   (cur_byte),
        .crc   (crc_val)
    );

    sdw_ack_timer #(.TMO_W(TMO_W)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (state_q == S_WAIT),
        .limit   (cfg_timeout),
        .expired (tmo_hit)
    );

    // ---------------- assertions ----------------
    // R1: a request only follows an arming edge or a repeat
    p_req_source_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dma_req) |-> $past(start) || $past(rx_ack && cfg_dma_repeat));

    // R4: no byte is offered before every word is in the slots
    p_tx_after_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_valid) |-> (wcnt_q == cnt_q));

    // R5: offered byte held while stalled
    p_tx_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid && !tx_ready && cfg_en |=> tx_valid && $stable(tx_data));

    // R6: status only rises on an acknowledge
    p_ack_source_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sts_ack) |-> $past(rx_ack));

    // R7: one-shot mode drops the request after the acknowledge
    p_oneshot_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_WAIT) && rx_ack && !cfg_dma_repeat |=> !dma_req);

    // R8: timeout error only comes from the wait state
    p_tmo_source_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_tmo) |-> $past(state_q == S_WAIT));

    // R9: dropping enable idles the channel at the next edge
    p_abort_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_en |=> !dma_req && !tx_valid);
endmodule

// File: tb/sdw_chan_seq_bench.sv
module sdw_chan_seq_bench;
    localparam int WORDS = 4;
    localparam int TMO_W = 16;
    localparam int CNT_W = $clog2(WORDS + 1);

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             cfg_en = 1'b0, cfg_dma_assist = 1'b0, cfg_dma_repeat = 1'b0, cfg_ack_ie = 1'b0;
    logic [CNT_W-1:0] cfg_word_cnt = '0;
    logic [7:0]       cfg_hdr = 8'h00;
    logic [31:0]      cfg_addr = '0;
    logic [TMO_W-1:0] cfg_timeout = 16'd40;
    logic             sts_ack_clr = 1'b0, err_clr = 1'b0;
    logic             dma_req, dma_valid = 1'b0;
    logic [31:0]      dma_data = '0;
    logic             tx_valid, tx_ready = 1'b0, tx_last;
    logic [7:0]       tx_data;
    logic             rx_ack = 1'b0;
    logic             sts_ack, err_tmo, irq;

    always #4 clk = ~clk; // 125 MHz

    sdw_chan_seq #(.WORDS(WORDS), .TMO_W(TMO_W)) u_sdw_chan_seq (.*);

    int n_tests = 0;
    int n_fail  = 0;
    logic [8:0]  exp_q[$];   // bit 8 = last flag
    logic [31:0] dq[$];
    int  rdy_mode = 0;       // 0 always, 1 every third cycle, 2 never
    bit  dma_gap = 1'b0;
    bit  ack_auto = 1'b1;
    bit  stray_ack = 1'b0;
    int  ack_cd = 0;
    int  frames_done = 0;
    int  cyc = 0;
    bit  done = 1'b0;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] ref_crc(input logic [7:0] c, input logic [7:0] d);
        logic [7:0] x;
        x = c ^ d;
        for (int b = 0; b < 8; b++) x = x[7] ? ((x << 1) ^ 8'h07) : (x << 1);
        return x;
    endfunction

    // driver: queue DMA words and the expected frame bytes
    task automatic push_frame(input logic [7:0] h, input logic [31:0] a, input int n,
                              input logic [31:0] w [4]);
        logic [7:0] c;
        logic [7:0] b;
        c = 8'h00;
        for (int i = 0; i < 5 + 4 * n; i++) begin
            if (i == 0) b = h;
            else if (i < 5) b = a[8 * (4 - i) +: 8];
            else b = w[(i - 5) / 4][8 * (3 - (i - 5) % 4) +: 8];
            c = ref_crc(c, b);
            exp_q.push_back({1'b0, b});
        end
        exp_q.push_back({1'b1, c});
        for (int i = 0; i < n; i++) dq.push_back(w[i]);
    endtask

    // monitor, DMA model, transmitter model and acknowledge responder
    always @(negedge clk) begin
        logic   rdy;
        logic [8:0] e;
        cyc++;
        rx_ack = 1'b0;
        if (stray_ack) begin
            rx_ack = 1'b1;
            stray_ack = 1'b0;
        end
        if (ack_cd != 0) begin
            ack_cd--;
            if (ack_cd == 0) rx_ack = 1'b1;
        end
        if (dma_req && dq.size() > 0 && (!dma_gap || cyc[0])) begin
            dma_valid = 1'b1;
            dma_data  = dq.pop_front();
        end else begin
            dma_valid = 1'b0;
        end
        rdy = (rdy_mode == 0) || (rdy_mode == 1 && (cyc % 3 == 0));
        tx_ready = rdy;
        if (tx_valid && rdy) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R3 unexpected byte", {24'h0, tx_data}, 32'h0);
            end else begin
                e = exp_q.pop_front();
                chk(tx_data == e[7:0] && tx_last == e[8], "R3 R4 frame byte/CRC",
                    {23'h0, tx_last, tx_data}, {23'h0, e});
            end
            if (tx_last) begin
                frames_done++;
                if (ack_auto) ack_cd = 3;
            end
        end
    end

    task automatic wcyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_frames(input int target);
        for (int i = 0; i < 600 && frames_done < target; i++) @(negedge clk);
    endtask

    task automatic arm(input int cnt);
        cfg_en = 1'b0;
        wcyc(2);
        cfg_word_cnt = CNT_W'(cnt);
        cfg_en = 1'b1;
        cfg_dma_assist = 1'b1;
    endtask

    initial begin
        wcyc(3);
        rst_n = 1'b1;
        wcyc(1);
        chk(!dma_req && !tx_valid && !sts_ack && !err_tmo && !irq, "reset state",
            {27'h0, dma_req, tx_valid, sts_ack, err_tmo, irq}, 32'h0);

        // ---- T1: assist gating, 2-word one-shot frame ----
        cfg_hdr = 8'hA5; cfg_addr = 32'h1234_5678; cfg_ack_ie = 1'b1; cfg_word_cnt = 3'd2;
        cfg_en = 1'b1;
        wcyc(4);
        chk(dma_req == 1'b0, "R1 no request without assist", {31'h0, dma_req}, 32'h0);
        push_frame(8'hA5, 32'h1234_5678, 2, '{32'hDEAD_BEEF, 32'h0102_0304, 32'h0, 32'h0});
        cfg_dma_assist = 1'b1;
        wcyc(1);
        chk(dma_req == 1'b1, "R1 request after arming", {31'h0, dma_req}, 32'h1);
        wait_frames(1);
        wcyc(6);
        chk(sts_ack == 1'b1, "R6 ack status set", {31'h0, sts_ack}, 32'h1);
        chk(irq == 1'b1, "R6 irq with enable", {31'h0, irq}, 32'h1);
        chk(dma_req == 1'b0, "R7 one-shot stays idle", {31'h0, dma_req}, 32'h0);
        sts_ack_clr = 1'b1;
        wcyc(1);
        sts_ack_clr = 1'b0;
        chk(sts_ack == 1'b0, "R6 write-1-to-clear", {31'h0, sts_ack}, 32'h0);

        // ---- T2: 4 words, DMA gaps, tx backpressure, irq masked, extra word left ----
        cfg_ack_ie = 1'b0; dma_gap = 1'b1; rdy_mode = 1;
        cfg_hdr = 8'h3C; cfg_addr = 32'hFFEE_0010;
        push_frame(8'h3C, 32'hFFEE_0010, 4,
                   '{32'h1111_2222, 32'h3333_4444, 32'h5555_6666, 32'h7777_8888});
        dq.push_back(32'hBAD0_BAD0);
        arm(4);
        wait_frames(2);
        wcyc(6);
        chk(dq.size() == 1, "R2 request dropped at count", dq.size(), 32'h1);
        chk(exp_q.size() == 0, "R3 whole frame sent", exp_q.size(), 32'h0);
        chk(sts_ack == 1'b1 && irq == 1'b0, "R6 irq masked", {30'h0, sts_ack, irq}, 32'h2);
        dq.delete();
        dma_gap = 1'b0; rdy_mode = 0;

        // ---- T3: repeat mode, one word per frame, count 0 clamps to 1 ----
        cfg_dma_repeat = 1'b1; cfg_hdr = 8'h81; cfg_addr = 32'h0000_0400;
        push_frame(8'h81, 32'h0000_0400, 1, '{32'hCAFE_F00D, 32'h0, 32'h0, 32'h0});
        push_frame(8'h81, 32'h0000_0400, 1, '{32'h0BAD_CAB1, 32'h0, 32'h0, 32'h0});
        arm(0);
        wait_frames(4);
        wcyc(6);
        chk(exp_q.size() == 0, "R2 count 0 acts as 1", exp_q.size(), 32'h0);
        chk(dma_req == 1'b1, "R7 repeat re-requests", {31'h0, dma_req}, 32'h1);
        cfg_en = 1'b0;
        wcyc(1);
        chk(dma_req == 1'b0, "R9 abort in load", {31'h0, dma_req}, 32'h0);
        cfg_dma_repeat = 1'b0;
        sts_ack_clr = 1'b1;
        wcyc(1);
        sts_ack_clr = 1'b0;

        // ---- T4: timeout, stray acknowledge ----
        ack_auto = 1'b0; cfg_timeout = 16'd6; cfg_hdr = 8'h07; cfg_addr = 32'h8000_0000;
        push_frame(8'h07, 32'h8000_0000, 1, '{32'h0000_00FF, 32'h0, 32'h0, 32'h0});
        arm(1);
        wait_frames(5);
        wcyc(12);
        chk(err_tmo == 1'b1, "R8 timeout error set", {31'h0, err_tmo}, 32'h1);
        chk(dma_req == 1'b0 && sts_ack == 1'b0, "R8 idle after timeout",
            {30'h0, dma_req, sts_ack}, 32'h0);
        stray_ack = 1'b1;
        wcyc(3);
        chk(sts_ack == 1'b0, "R8 ack outside wait ignored", {31'h0, sts_ack}, 32'h0);
        err_clr = 1'b1;
        wcyc(1);
        err_clr = 1'b0;
        chk(err_tmo == 1'b0, "R8 error clear", {31'h0, err_tmo}, 32'h0);
        ack_auto = 1'b1;

        // ---- T5: stall then abort during send ----
        begin
            logic [7:0] held;
            rdy_mode = 2;
            push_frame(8'h55, 32'h8000_0000, 1, '{32'h1357_9BDF, 32'h0, 32'h0, 32'h0});
            cfg_hdr = 8'h55;
            arm(1);
            for (int i = 0; i < 100 && !tx_valid; i++) @(negedge clk);
            held = tx_data;
            wcyc(3);
            chk(tx_valid && tx_data == held, "R5 byte held under stall",
                {24'h0, tx_data}, {24'h0, held});
            cfg_en = 1'b0;
            wcyc(1);
            chk(tx_valid == 1'b0, "R9 abort in send", {31'h0, tx_valid}, 32'h0);
            exp_q.delete();
            rdy_mode = 0;
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule